// File: doc/BRIEF.md
# Security Level Access Gate

This block keeps a one-byte security setting and, for every request presented to it, decides whether the requested class of operation may go ahead. A requester presents an operation code and, for a security change, the new security value. One clock later the block answers with a permit flag and a one-character reply code: a dot for a granted request, `P` for a refused write-type request, `L` for a refused read-type request.

The security setting has three legal values, ordered from open to strict. It can only move toward stricter values through a request. The only way back to the open value is a separate full-erase strobe. That strobe also pulses a clear signal that carries the values to which the two boot configuration bytes must return. The setting is held in registers that stand in for non-volatile storage; reset loads the strict value.

Top module: `sec_access_gate`

## Requirements
- R1: After reset, `sec_byte` is FCh, `resp_valid` is 0, `cfg_clear` is 0, and `stat_init` and `vec_init` are 00h.
- R2: A request sampled with `req_valid` high at a clock edge gives `resp_valid` high for exactly the following cycle, together with `resp_permit` and `resp_code`. A grant carries code 2Eh ('.'). Opcodes are: 0 flash write, 1 flash read, 2 configuration write, 3 configuration read, 4 security raise, 5 security read, 6 block erase, 7 full erase, 8 blank check, 9 identification read.
- R3: At the open level (`sec_byte` FFh), opcodes 0, 1, 2, 3, 5, 6, 7, 8 and 9 are granted.
- R4: A security raise (opcode 4) is granted only when `req_value` is FEh or FCh and that value is strictly stricter than the current level (FFh < FEh < FCh). When it is granted, `sec_byte` takes `req_value` in the same cycle that the response appears. Any other value, including unrecognised ones, is refused with 'P' (50h) and leaves `sec_byte` unchanged.
- R5: At the write-protected level (FEh), flash write, configuration write and block erase are refused with 'P'. Flash read, configuration read and security read are granted.
- R6: At the read-write-protected level (FCh), flash read and configuration read are refused with 'L' (4Ch). Flash write, configuration write, block erase and security raise are refused with 'P'. Security read is granted.
- R7: Full erase, blank check and identification read requests are granted at every level.
- R8: `erase_stb` high at an edge makes `sec_byte` FFh in the next cycle. For that one cycle `cfg_clear` is 1, `stat_init` is FFh and `vec_init` is F0h. In all other cycles `cfg_clear` is 0 and both init outputs are 00h.
- R9: When `erase_stb` and a granted security raise arrive at the same edge, the erase wins (`sec_byte` becomes FFh). The response is still decided from the level held before that edge.
- R10: Opcodes 10 to 15 are refused with 'P' at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation class code |
| req_value | input | 8 | New security value for a raise request |
| erase_stb | input | 1 | Full-erase completion strobe |
| resp_valid | output | 1 | Response present this cycle |
| resp_permit | output | 1 | Request granted |
| resp_code | output | 8 | Reply character ('.', 'P' or 'L') |
| sec_byte | output | 8 | Current security byte |
| cfg_clear | output | 1 | Configuration bytes must be reloaded |
| stat_init | output | 8 | Boot status reload value during `cfg_clear` |
| vec_init | output | 8 | Boot vector reload value during `cfg_clear` |

## Verification
The bench reaches every level from a fresh erase. At each level it sends every opcode, and for the raise request it tries all 256 target values. A design that let the level move sideways or back, or that accepted an unlisted byte, would show a changed `sec_byte` after a refused raise. The bench also checks the reply character for each refusal, because a design that swapped 'L' and 'P' would still get the permit bit right. It collides an erase with a granted raise in the same cycle, which catches a design that gives the raise priority or decides from the post-erase level. It also checks that the reload values appear for exactly one cycle.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

  localparam int OP_W   = 4;
  localparam int BYTE_W = 8;

  localparam logic [OP_W-1:0] OP_FLASH_WR   = 4'd0;
  localparam logic [OP_W-1:0] OP_FLASH_RD   = 4'd1;
  localparam logic [OP_W-1:0] OP_CFG_WR     = 4'd2;
  localparam logic [OP_W-1:0] OP_CFG_RD     = 4'd3;
  localparam logic [OP_W-1:0] OP_SEC_RAISE  = 4'd4;
  localparam logic [OP_W-1:0] OP_SEC_RD     = 4'd5;
  localparam logic [OP_W-1:0] OP_BLK_ERASE  = 4'd6;
  localparam logic [OP_W-1:0] OP_FULL_ERASE = 4'd7;
  localparam logic [OP_W-1:0] OP_BLANK_CHK  = 4'd8;
  localparam logic [OP_W-1:0] OP_ID_RD      = 4'd9;

  localparam logic [BYTE_W-1:0] SEC_OPEN   = 8'hFF;
  localparam logic [BYTE_W-1:0] SEC_WPROT  = 8'hFE;
  localparam logic [BYTE_W-1:0] SEC_RWPROT = 8'hFC;

  localparam logic [BYTE_W-1:0] REPLY_OK    = 8'h2E;
  localparam logic [BYTE_W-1:0] REPLY_WDENY = 8'h50;
  localparam logic [BYTE_W-1:0] REPLY_RDENY = 8'h4C;

  typedef enum logic [1:0] {
    LV_OPEN   = 2'd0,
    LV_WPROT  = 2'd1,
    LV_RWPROT = 2'd2,
    LV_BAD    = 2'd3
  } sec_lvl_e;

  // Strictness rank of a security byte; unknown bytes map to LV_BAD.
  function automatic sec_lvl_e sec_rank(input logic [BYTE_W-1:0] b);
    case (b)
      SEC_OPEN:   return LV_OPEN;
      SEC_WPROT:  return LV_WPROT;
      SEC_RWPROT: return LV_RWPROT;
      default:    return LV_BAD;
    endcase
  endfunction

  // A raise is legal when the target is a known protected level above the current one.
  function automatic logic raise_ok(input sec_lvl_e cur, input logic [BYTE_W-1:0] tgt);
    sec_lvl_e t;
    t = sec_rank(tgt);
    return ((t == LV_WPROT) || (t == LV_RWPROT)) && (t > cur);
  endfunction

  function automatic logic is_read_class(input logic [OP_W-1:0] op);
    return (op == OP_FLASH_RD) || (op == OP_CFG_RD);
  endfunction

endpackage

// File: rtl/sec_policy.sv
module sec_policy
  import sec_gate_pkg::*;
(
  input  sec_lvl_e          lvl,
  input  logic [OP_W-1:0]   op,
  input  logic [BYTE_W-1:0] tgt,
  output logic              allow,
  output logic              raise_go,
  output logic [BYTE_W-1:0] reply
);

  logic raise_legal;
  assign raise_legal = raise_ok(lvl, tgt);

  always_comb begin
    allow = 1'b0;
    case (op)
      OP_FLASH_WR, OP_CFG_WR, OP_BLK_ERASE: allow = (lvl == LV_OPEN);
      OP_FLASH_RD, OP_CFG_RD:               allow = (lvl == LV_OPEN) || (lvl == LV_WPROT);
      OP_SEC_RAISE:                         allow = raise_legal;
      OP_SEC_RD, OP_FULL_ERASE,
      OP_BLANK_CHK, OP_ID_RD:               allow = 1'b1;
      default:                              allow = 1'b0;
    endcase
  end

  assign raise_go = (op == OP_SEC_RAISE) && raise_legal;

  always_comb begin
    if (allow)                   reply = REPLY_OK;
    else if (is_read_class(op))  reply = REPLY_RDENY;
    else                         reply = REPLY_WDENY;
  end

  always_comb begin
    assert_raise_strict_R4: assert (!raise_go || (sec_rank(tgt) > lvl));
  end

endmodule

// File: rtl/sec_store.sv
module sec_store
  import sec_gate_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SEC_POR = SEC_RWPROT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_val,
  input  logic              wipe,
  output logic [BYTE_W-1:0] sec_q,
  output logic              wiped_q
);

  sec_lvl_e cur_rank;
  assign cur_rank = sec_rank(sec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= SEC_POR;
      wiped_q <= 1'b0;
    end else begin
      wiped_q <= wipe;
      if (wipe)       sec_q <= SEC_OPEN;
      else if (wr_en) sec_q <= wr_val;
    end
  end

  assert_legal_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_rank != LV_BAD);

  assert_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe |=> cur_rank >= $past(cur_rank));

  assert_wipe_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (cur_rank == LV_OPEN) && wiped_q);

endmodule

// File: rtl/sec_reply.sv
module sec_reply
  import sec_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              allow,
  input  logic [BYTE_W-1:0] reply,
  output logic              resp_valid,
  output logic              resp_permit,
  output logic [BYTE_W-1:0] resp_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_permit <= 1'b0;
      resp_code   <= '0;
    end else begin
      resp_valid  <= req_valid;
      resp_permit <= req_valid && allow;
      resp_code   <= req_valid ? reply : '0;
    end
  end

  assert_one_cycle_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  assert_permit_in_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_permit |-> resp_valid && (resp_code == REPLY_OK));

endmodule

// File: rtl/sec_access_gate.sv
module sec_access_gate
  import sec_gate_pkg::*;
#(
  parameter logic [7:0] SEC_POR   = 8'hFC,
  parameter logic [7:0] STAT_INIT = 8'hFF,
  parameter logic [7:0] VEC_INIT  = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_op,
  input  logic [7:0] req_value,
  input  logic       erase_stb,
  output logic       resp_valid,
  output logic       resp_permit,
  output logic [7:0] resp_code,
  output logic [7:0] sec_byte,
  output logic       cfg_clear,
  output logic [7:0] stat_init,
  output logic [7:0] vec_init
);

  sec_lvl_e          lvl_now;
  logic              pol_allow;
  logic              pol_raise;
  logic [BYTE_W-1:0] pol_reply;
  logic              raise_commit;

  assign lvl_now      = sec_rank(sec_byte);
  assign raise_commit = req_valid && pol_raise;

  sec_policy u_policy (
    .lvl      (lvl_now),
    .op       (req_op),
    .tgt      (req_value),
    .allow    (pol_allow),
    .raise_go (pol_raise),
    .reply    (pol_reply)
  );

  sec_store #(.SEC_POR(SEC_POR)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (raise_commit),
    .wr_val  (req_value),
    .wipe    (erase_stb),
    .sec_q   (sec_byte),
    .wiped_q (cfg_clear)
  );

  sec_reply u_reply (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .allow       (pol_allow),
    .reply       (pol_reply),
    .resp_valid  (resp_valid),
    .resp_permit (resp_permit),
    .resp_code   (resp_code)
  );

  assign stat_init = cfg_clear ? STAT_INIT : 8'h00;
  assign vec_init  = cfg_clear ? VEC_INIT  : 8'h00;

  assert_rd_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_FLASH_RD) && (lvl_now == LV_RWPROT))
      |=> resp_valid && !resp_permit && (resp_code == REPLY_RDENY));

  assert_always_open_ops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_op == OP_FULL_ERASE) || (req_op == OP_BLANK_CHK) || (req_op == OP_ID_RD)))
      |=> resp_permit);

  assert_wprot_write_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_FLASH_WR) && (lvl_now == LV_WPROT))
      |=> !resp_permit && (resp_code == REPLY_WDENY));

  assert_erase_beats_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_stb && raise_commit) |=> sec_byte == SEC_OPEN);

  assert_undef_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op > OP_ID_RD)) |=> !resp_permit && (resp_code == REPLY_WDENY));

endmodule

// File: tb/sim_sec_access_gate.sv
`timescale 1ns/1ps
module sim_sec_access_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic [7:0] req_value = 8'd0;
  logic       erase_stb = 1'b0;
  logic       resp_valid, resp_permit, cfg_clear;
  logic [7:0] resp_code, sec_byte, stat_init, vec_init;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sec_access_gate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_value(req_value), .erase_stb(erase_stb), .resp_valid(resp_valid),
    .resp_permit(resp_permit), .resp_code(resp_code), .sec_byte(sec_byte),
    .cfg_clear(cfg_clear), .stat_init(stat_init), .vec_init(vec_init)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Level byte for levels 0,1,2.
  function automatic logic [7:0] lvl_byte(input int l);
    return (l == 0) ? 8'hFF : (l == 1) ? 8'hFE : 8'hFC;
  endfunction

  // Granted-opcode masks per level (bit n = opcode n), raise handled apart.
  function automatic bit exp_grant(input int l, input int op, input int t);
    logic [15:0] m;
    int tr;
    if (op == 4) begin
      tr = (t == 8'hFE) ? 1 : (t == 8'hFC) ? 2 : 0;
      return (tr != 0) && (tr > l);
    end
    m = (l == 0) ? 16'h03EF : (l == 1) ? 16'h03AA : 16'h03A0;
    return m[op];
  endfunction

  task automatic do_erase();
    erase_stb = 1'b1;
    @(negedge clk);
    erase_stb = 1'b0;
    chk(cfg_clear == 1'b1 && sec_byte == 8'hFF, "R8 erase opens", {7'd0, cfg_clear, sec_byte}, 16'h01FF);
    chk(stat_init == 8'hFF && vec_init == 8'hF0, "R8 reload values", {stat_init, vec_init}, 16'hFFF0);
    @(negedge clk);
    chk(cfg_clear == 1'b0 && stat_init == 8'h00 && vec_init == 8'h00, "R8 clear one cycle",
        {7'd0, cfg_clear, stat_init}, 16'h0000);
  endtask

  task automatic request(input int op, input int v);
    req_valid = 1'b1;
    req_op    = op[3:0];
    req_value = v[7:0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_level(input int l);
    do_erase();
    if (l > 0) begin
      request(4, lvl_byte(l));
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sec_byte == 8'hFC, "R1 reset level", {8'd0, sec_byte}, 16'h00FC);
    chk(!resp_valid && !cfg_clear && stat_init == 0 && vec_init == 0, "R1 reset outputs",
        {6'd0, resp_valid, cfg_clear, stat_init}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive sweep: level x opcode (x every target for raise)
    for (int l = 0; l < 3; l++) begin
      for (int op = 0; op < 16; op++) begin
        for (int t = 0; t < ((op == 4) ? 256 : 1); t++) begin
          int tv;
          bit g;
          string tag;
          logic [7:0] ecode, esec;
          tv = (op == 4) ? t : (op * 17) & 8'hFF;
          set_level(l);
          g = exp_grant(l, op, tv);
          ecode = g ? 8'h2E : ((op == 1 || op == 3) ? 8'h4C : 8'h50);
          esec  = (op == 4 && g) ? tv[7:0] : lvl_byte(l);
          if (op == 4)                     tag = "R4 raise";
          else if (op >= 10)               tag = "R10 undefined op";
          else if (op >= 7 && op <= 9)     tag = "R7 always granted";
          else if (l == 0)                 tag = "R3 open level";
          else if (l == 1)                 tag = "R5 write protect";
          else                             tag = "R6 read-write protect";
          request(op, tv);
          chk(resp_valid == 1'b1, "R2 response valid", {15'd0, resp_valid}, 16'h0001);
          chk(resp_permit == g && resp_code == ecode, tag, {7'd0, resp_permit, resp_code}, {7'd0, g, ecode});
          chk(sec_byte == esec, tag, {8'd0, sec_byte}, {8'd0, esec});
          @(negedge clk);
          chk(resp_valid == 1'b0 && sec_byte == esec, "R2 single cycle", {7'd0, resp_valid, sec_byte}, {8'd0, esec});
        end
      end
    end

    // R9: erase collides with a granted raise
    set_level(0);
    erase_stb = 1'b1;
    request(4, 8'hFC);
    erase_stb = 1'b0;
    chk(resp_permit == 1'b1 && resp_code == 8'h2E, "R9 decided on old level", {7'd0, resp_permit, resp_code}, 16'h012E);
    chk(sec_byte == 8'hFF && cfg_clear == 1'b1, "R9 erase wins", {7'd0, cfg_clear, sec_byte}, 16'h01FF);
    @(negedge clk);

    // R9: erase at level 2 with a refused read, response uses old level
    set_level(2);
    erase_stb = 1'b1;
    request(1, 0);
    erase_stb = 1'b0;
    chk(resp_permit == 1'b0 && resp_code == 8'h4C, "R9 old level read lock", {7'd0, resp_permit, resp_code}, 16'h004C);
    chk(sec_byte == 8'hFF, "R9 level opened", {8'd0, sec_byte}, 16'h00FF);
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule